// File: doc/BRIEF.md
# CRC-Gated Acknowledge Responder

This block sits between a byte-wide packet receiver and a message transmitter on a half-duplex single-wire link. As each byte arrives, it folds the byte into a running CRC-32. The verdict is therefore known in the same cycle as the last byte, with nothing buffered. A packet that checks out starts an acknowledge request at once. A packet that fails draws no reply and leaves all state as it was.

The acknowledge request carries a fixed message-type code and the message ID copied from the packet it confirms. The block keeps a receive counter of newly accepted packets and raises a one-cycle delivery strobe for each one. A packet whose ID repeats the most recently acknowledged ID is acknowledged again. It is not counted and not delivered. While an acknowledge waits for the transmitter, incoming traffic is dropped.

Top module: `crc_ack_responder`

## Requirements
- R1: After reset, `tx_req`, `deliver` and `rx_id_count` are all zero.
- R2: A packet is the bytes from a `rx_sop` byte through a `rx_eop` byte. Its last four bytes are the ones' complement of the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones) over the preceding bytes, least significant byte first. When such a packet's final byte is taken at a clock edge, `tx_req` is high after that same edge.
- R3: `tx_ack_id` equals bits [ID_W-1:0] of the packet's first byte, and `tx_msg_type` equals `ACK_TYPE`.
- R4: A packet whose trailing four bytes do not match produces no `tx_req`, no `deliver` and no change of `rx_id_count`.
- R5: `rx_id_count` increments by one, modulo 2^ID_W (from 7 to 0 at the default width), for each good packet that is not a repeat. It changes at no other time.
- R6: `deliver` pulses for exactly one cycle, together with the rise of `tx_req`, for a good non-repeat packet. A good packet whose ID equals the last acknowledged ID is acknowledged but neither delivered nor counted.
- R7: Once raised, `tx_req` and `tx_ack_id` hold until a cycle with `tx_done` high, and `tx_req` falls after that edge.
- R8: Bytes taken while `tx_req` is high are ignored. This includes the rest of a packet whose `rx_sop` byte arrived while `tx_req` was high, even after `tx_done`. Such a packet yields no acknowledge, no delivery and no count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_byte | input | 8 | Received byte |
| rx_sop | input | 1 | Marks the first byte of a packet |
| rx_eop | input | 1 | Marks the last byte of a packet |
| tx_done | input | 1 | Transmitter has finished the acknowledge |
| tx_req | output | 1 | Acknowledge transmit request |
| tx_ack_id | output | ID_W | Message ID carried by the acknowledge |
| tx_msg_type | output | 5 | Acknowledge message-type code |
| deliver | output | 1 | One-cycle strobe for a new verified packet |
| rx_id_count | output | ID_W | Receive counter of new verified packets |

## Verification
The bench builds the block with the default 3-bit ID and the default type code. With a 3-bit ID, a run of eight fresh packets carries the receive counter through its wrap from 7 to 0, so the rollover is checked directly. The short ID also makes repeated IDs common, which covers the re-acknowledge path. Packets of different lengths, a corrupted check byte, and a packet that overlaps a pending acknowledge (with `tx_done` arriving in mid-packet) exercise the CRC verdict and the busy rule.

// File: rtl/crc_ack_responder.sv
module crc_ack_responder #(
  parameter int         ID_W     = 3,
  parameter logic [4:0] ACK_TYPE = 5'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_sop,
  input  logic            rx_eop,
  input  logic            tx_done,
  output logic            tx_req,
  output logic [ID_W-1:0] tx_ack_id,
  output logic [4:0]      tx_msg_type,
  output logic            deliver,
  output logic [ID_W-1:0] rx_id_count
);
  localparam logic [31:0] POLY    = 32'hEDB88320;
  localparam logic [31:0] RESIDUE = 32'hDEBB20E3;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [31:0]     crc_q;
  logic [ID_W-1:0] id_q, last_id;
  logic            in_pkt, have_last;

  wire             take   = rx_valid && !tx_req && (rx_sop || in_pkt);
  wire [31:0]      crc_nx = crc_byte(rx_sop ? 32'hFFFFFFFF : crc_q, rx_byte);
  wire             fin    = take && rx_eop;
  wire             good   = (crc_nx == RESIDUE);
  wire [ID_W-1:0]  id_now = rx_sop ? rx_byte[ID_W-1:0] : id_q;
  wire             dup    = have_last && (id_now == last_id);

  assign tx_msg_type = ACK_TYPE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q       <= '1;
      id_q        <= '0;
      in_pkt      <= 1'b0;
      tx_req      <= 1'b0;
      tx_ack_id   <= '0;
      deliver     <= 1'b0;
      rx_id_count <= '0;
      last_id     <= '0;
      have_last   <= 1'b0;
    end else begin
      deliver <= 1'b0;
      if (take) begin
        crc_q  <= crc_nx;
        in_pkt <= !rx_eop;
        if (rx_sop) id_q <= rx_byte[ID_W-1:0];
      end else if (rx_valid && rx_sop) begin
        in_pkt <= 1'b0;
      end
      if (fin && good) begin
        tx_req    <= 1'b1;
        tx_ack_id <= id_now;
        last_id   <= id_now;
        have_last <= 1'b1;
        if (!dup) begin
          deliver     <= 1'b1;
          rx_id_count <= rx_id_count + 1'b1;
        end
      end else if (tx_done) begin
        tx_req <= 1'b0;
      end
    end
  end

  p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin && good |=> tx_req);
  p_ack_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin && good |=> tx_ack_id == $past(id_now));
  p_bad_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !good |=> !tx_req && !deliver && $stable(rx_id_count));
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_id_count != $past(rx_id_count)) |->
      deliver && rx_id_count == ID_W'($past(rx_id_count) + 1'b1));
  p_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && good && dup |=> !deliver);
  p_deliver_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> $rose(tx_req));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req && $stable(tx_ack_id));
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_req) |-> !deliver && $stable(rx_id_count));
endmodule

// File: tb/crc_ack_responder_tb.sv
module crc_ack_responder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, tx_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_req, deliver;
  logic [2:0] tx_ack_id, rx_id_count;
  logic [4:0] tx_msg_type;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  crc_ack_responder #(.ID_W(3), .ACK_TYPE(5'd1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .tx_done(tx_done), .tx_req(tx_req),
    .tx_ack_id(tx_ack_id), .tx_msg_type(tx_msg_type), .deliver(deliver),
    .rx_id_count(rx_id_count));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] b[0:19], input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, b[i]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send(input int n, input logic [2:0] id, input bit corrupt, input int done_at);
    logic [7:0]  pkt[0:19];
    logic [31:0] fcs;
    pkt[0] = 8'hA8 | {5'h0, id};
    for (int i = 1; i < n; i++) pkt[i] = 8'(i * 37 + n);
    fcs = ref_crc(pkt, n);
    for (int i = 0; i < 4; i++) pkt[n+i] = fcs[8*i +: 8];
    if (corrupt) pkt[n+1] = pkt[n+1] ^ 8'h08;
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = pkt[i];
      rx_sop = (i == 0); rx_eop = (i == n + 3); tx_done = (i == done_at);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; tx_done = 1'b0;
  endtask

  task automatic release_ack(input logic [2:0] id);
    @(negedge clk); @(negedge clk);
    chk("R7 hold req", tx_req, 1);
    chk("R7 hold id", tx_ack_id, id);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R7 req falls", tx_req, 0);
  endtask

  task automatic t_reset();
    chk("R1 req", tx_req, 0);
    chk("R1 deliver", deliver, 0);
    chk("R1 count", rx_id_count, 0);
  endtask

  task automatic t_good(input int n, input logic [2:0] id);
    send(n, id, 1'b0, -1);
    exp_cnt = (exp_cnt + 1) % 8;
    chk("R2 req", tx_req, 1);
    chk("R3 id", tx_ack_id, id);
    chk("R3 type", tx_msg_type, 1);
    chk("R6 deliver", deliver, 1);
    chk("R5 count", rx_id_count, exp_cnt);
    release_ack(id);
    chk("R6 one pulse", deliver, 0);
  endtask

  task automatic t_bad();
    send(6, 3'd2, 1'b1, -1);
    chk("R4 req", tx_req, 0);
    chk("R4 deliver", deliver, 0);
    chk("R4 count", rx_id_count, exp_cnt);
    @(negedge clk);
    chk("R4 req later", tx_req, 0);
  endtask

  task automatic t_dup(input logic [2:0] id);
    send(4, id, 1'b0, -1);
    chk("R6 dup req", tx_req, 1);
    chk("R6 dup id", tx_ack_id, id);
    chk("R6 dup deliver", deliver, 0);
    chk("R6 dup count", rx_id_count, exp_cnt);
    release_ack(id);
  endtask

  task automatic t_busy();
    send(3, 3'd4, 1'b0, -1);
    exp_cnt = (exp_cnt + 1) % 8;
    chk("R8 first req", tx_req, 1);
    send(8, 3'd6, 1'b0, 2);
    chk("R8 req", tx_req, 0);
    chk("R8 deliver", deliver, 0);
    chk("R8 count", rx_id_count, exp_cnt);
    t_good(5, 3'd6);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 8; k++) t_good(2 + k, 3'(k + 1));
    chk("R5 wrapped", rx_id_count, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_good(5, 3'd3);
    t_bad();
    t_dup(3'd3);
    t_good(1, 3'd0);
    t_busy();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule